// File: doc/BRIEF.md
# Fastest-Wins Synchronizable Period Oscillator

This block produces the switching-period tick for a phase-shift PWM core. A local counter runs at a programmed period. At the end of each local period the block raises a one-cycle period-start strobe and drives a short pulse onto a shared, wired-OR sync line. Any number of units, and an optional external clock, may share that line.

A rising edge on the line that comes from another source restarts the local period early. The whole group therefore locks to whichever source has the shortest period, and the slower units never reach their own terminal count. A unit whose line is cut off, or that sees no foreign edges, runs at its own period. The line input is asynchronous and passes through two flops first. The unit masks its own pulse so that it does not count that pulse as a foreign event.

Top module: `fastsync_osc`

## Requirements
- R1: While reset is asserted, and after reset until the first period end, `cycle_start_o`, `sync_drive_o` and `sync_pulse_o` are all low.
- R2: With no foreign rising edge on the line, `cycle_start_o` pulses once every P cycles, where P is `period_i` or `PULSE_W+4` if that is larger.
- R3: A rising edge on `sync_line_i` that is not masked restarts the local period, so the strobe spacing follows a faster source on the line, including an external clock.
- R4: When two units share the line, both settle to the shorter of their periods. The slower unit never drives the line while it is locked.
- R5: `cycle_start_o` is high for exactly one clock cycle per period.
- R6: At each local period end, `sync_drive_o` and `sync_pulse_o` rise in the same cycle as the strobe. They stay high for exactly `PULSE_W` cycles. A restart caused by the line does not drive the line.
- R7: A rising edge seen within `PULSE_W+3` cycles after the unit's own period end is ignored. The unit's own pulse on the line therefore leaves its period unchanged.
- R8: After the shared line is disconnected, each unit returns to its own programmed period.
- R9: A `period_i` value below `PULSE_W+4` acts as `PULSE_W+4`.
- R10: A new `period_i` value takes effect from the current count. If the count is already at or past the new terminal value, the period ends at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CNT_W | Local period in clock cycles |
| sync_line_i | input | 1 | Asynchronous level of the shared sync line |
| sync_drive_o | output | 1 | Enable for driving the sync line |
| sync_pulse_o | output | 1 | Level of the pulse driven onto the line |
| cycle_start_o | output | 1 | One-cycle strobe at the start of each period |

## Verification
The bench connects two units through a switchable link. Each unit also always sees its own pulse. This exposes a design that fails to mask its own pulse: it would restart a few cycles after each period end and run far too fast. The bench checks that the faster unit is unaffected and that the slower unit never drives. A design that let the slower unit drive, or that restarted on line levels instead of edges, would break the 40-cycle spacing. An external 25-cycle clock must pull both units down to 25 cycles. Cutting the link must return each unit to its own rate. The bench also programs a period below the minimum, expecting `PULSE_W+4` cycles rather than a wrapping or stuck counter. It changes the period during a run, and it measures the width of each driven pulse.

// File: rtl/fastsync_osc.sv
module fastsync_osc #(
  parameter int CNT_W   = 16,
  parameter int PULSE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic             sync_line_i,
  output logic             sync_drive_o,
  output logic             sync_pulse_o,
  output logic             cycle_start_o
);

  localparam int MIN_PER  = PULSE_W + 4;
  localparam int MASK_LEN = PULSE_W + 3;
  localparam int PW_W     = $clog2(MASK_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] eff_per;
  logic [2:0]       line_q;
  logic [PW_W-1:0]  drv_cnt;
  logic [PW_W-1:0]  mask_cnt;
  logic             start_q;

  assign eff_per = (period_i < CNT_W'(MIN_PER)) ? CNT_W'(MIN_PER) : period_i;

  wire term_hit = (cnt >= eff_per - CNT_W'(1));
  wire line_rise = line_q[1] & ~line_q[2];
  wire masked = (mask_cnt != '0);
  wire foreign = line_rise & ~masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      line_q   <= '0;
      drv_cnt  <= '0;
      mask_cnt <= '0;
      start_q  <= 1'b0;
    end else begin
      line_q <= {line_q[1:0], sync_line_i};
      if (term_hit) begin
        cnt      <= '0;
        start_q  <= 1'b1;
        drv_cnt  <= PW_W'(PULSE_W);
        mask_cnt <= PW_W'(MASK_LEN);
      end else begin
        cnt      <= foreign ? '0 : cnt + CNT_W'(1);
        start_q  <= foreign;
        drv_cnt  <= (drv_cnt != '0) ? drv_cnt - PW_W'(1) : '0;
        mask_cnt <= masked ? mask_cnt - PW_W'(1) : '0;
      end
    end
  end

  assign sync_drive_o  = (drv_cnt != '0);
  assign sync_pulse_o  = (drv_cnt != '0);
  assign cycle_start_o = start_q;

  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  a_r6_drive_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_drive_o) |-> start_q);

  a_r7_drive_masked: assert property (@(posedge clk) disable iff (!rst_n)
    sync_drive_o |-> masked);

  a_r6_pulse_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_drive_o) |-> !start_q);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> cnt == '0);

endmodule

// File: tb/fastsync_osc_test.sv
module fastsync_osc_test;
  localparam int CNT_W = 16;
  localparam int PW    = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [CNT_W-1:0] per_a = 40, per_b = 60;
  logic link = 0, ext_en = 0, ext = 0;
  logic drv_a, pls_a, st_a, drv_b, pls_b, st_b;

  wire line_a = pls_a | (link & pls_b) | ext;
  wire line_b = pls_b | (link & pls_a) | ext;

  always #2 clk = ~clk;

  fastsync_osc #(.CNT_W(CNT_W), .PULSE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .period_i(per_a), .sync_line_i(line_a),
    .sync_drive_o(drv_a), .sync_pulse_o(pls_a), .cycle_start_o(st_a));

  fastsync_osc #(.CNT_W(CNT_W), .PULSE_W(PW)) uut_b (
    .clk(clk), .rst_n(rst_n), .period_i(per_b), .sync_line_i(line_b),
    .sync_drive_o(drv_b), .sync_pulse_o(pls_b), .cycle_start_o(st_b));

  int compared = 0, mismatched = 0;
  int cyc = 0;
  int last_a = 0, last_b = 0, wid_a = 0, ext_cnt = 0, b_rises = 0;
  logic drv_a_d = 0, drv_b_d = 0;
  int    qa[$], qb[$], qw[$];
  string qa_tag[$], qb_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: samples at negedge, pops expected items
  always @(negedge clk) begin
    if (ext_en) begin
      ext_cnt = (ext_cnt + 1) % 25;
      ext = (ext_cnt < 2);
    end else ext = 0;
    if (rst_n) begin
      if (st_a) begin
        if (qa.size() > 0) check(qa_tag.pop_front(), cyc - last_a, qa.pop_front());
        last_a = cyc;
      end
      if (st_b) begin
        if (qb.size() > 0) check(qb_tag.pop_front(), cyc - last_b, qb.pop_front());
        last_b = cyc;
      end
      if (drv_a) wid_a++;
      if (drv_a_d && !drv_a) begin
        if (qw.size() > 0) check("R6 pulse width", wid_a, qw.pop_front());
        wid_a = 0;
      end
      if (drv_b && !drv_b_d) b_rises++;
      if (drv_a != pls_a) check("R6 pulse equals enable", pls_a, drv_a);
      drv_a_d = drv_a;
      drv_b_d = drv_b;
    end
  end

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_phase(string tag_a, int ea, string tag_b, int eb, int n);
    for (int i = 0; i < n; i++) begin
      if (ea > 0) begin qa.push_back(ea); qa_tag.push_back(tag_a); end
      if (eb > 0) begin qb.push_back(eb); qb_tag.push_back(tag_b); end
    end
    wait (qa.size() == 0 && qb.size() == 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset strobe", int'(st_a), 0);
    check("R1 reset drive", int'(drv_a), 0);
    rst_n = 1;
    settle(5);
    check("R1 quiet after reset strobe", int'(st_a | st_b), 0);
    check("R1 quiet after reset drive", int'(drv_a | drv_b | pls_a), 0);

    // R2, R7: isolated units, own pulse on own line
    settle(150);
    for (int i = 0; i < 4; i++) qw.push_back(PW);
    expect_phase("R2 free run A", 40, "R7 own pulse ignored B", 60, 4);
    check("R6 widths consumed", qw.size(), 0);

    // R4: shared line, fastest wins
    link = 1;
    settle(300);
    b_rises = 0;
    expect_phase("R4 fast unit keeps period", 40, "R4 slow unit follows", 40, 5);
    check("R4 slow unit never drives", b_rises, 0);

    // R3: external faster clock
    ext_en = 1;
    settle(200);
    expect_phase("R3 A follows external", 25, "R3 B follows external", 25, 5);

    // R8: disconnect
    ext_en = 0;
    link = 0;
    settle(300);
    expect_phase("R8 A own period", 40, "R8 B own period", 60, 4);

    // R9: minimum period clamp
    per_a = 2;
    settle(100);
    expect_phase("R9 clamp to min", PW + 4, "", 0, 5);

    // R10: runtime period change, including wrap from past terminal
    per_a = 50;
    settle(200);
    per_a = 30;
    settle(200);
    expect_phase("R10 new period", 30, "", 0, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule